// File: doc/BRIEF.md
# Address-decoded NAND flash bus bridge

This block connects a simple memory-mapped byte bus to the pins of a raw 8-bit NAND flash device. It has no command or address registers. Inside the flash window, the low address bits of each byte access choose which flash control lines the access asserts. A command byte therefore goes out as a byte write to an offset with the chip-select and command-latch bits set. An address byte uses the chip-select and address-latch bits. Data moves through an offset that has only the chip-select bit set.

Each flash access runs through four phases: one setup cycle, a write or read strobe of programmable width, a hold phase and a recovery phase. The host bus stalls until the recovery phase ends. A small register space sits beside the window. It holds a control register for flash mode, chip enable, chip-select routing and line polarities. It also holds a timing register for the phase lengths, and a status byte that shows the flash ready line and a sticky completion flag that software can poll.

Top module: `nand_bridge`

## Requirements
- R1: In the flash window (bus_addr bit 7 = 0), offset bit 2 drives fl_ale and bit 3 drives fl_cle (both active-high), and bit 5 drives the spare-select line and bit 6 the write-protect line. Each of these lines is asserted from the setup cycle through the last hold cycle, and is inactive in recovery and idle.
- R2: Offset bit 4 asserts a chip-select line only while control bit 0 (flash mode) and control bit 20 (chip enable) are both set. Otherwise both chip-select pins stay inactive, whatever the offset is.
- R3: When control bits 1 and 10 are both set, chip select is driven on fl_cs[1]; otherwise it is driven on fl_cs[0]. When control bits 1 and 8 are both set, the ready input is taken from fl_rdy[1]; otherwise from fl_rdy[0].
- R4: A flash write holds fl_we_n low for the write wait count, after exactly one setup cycle. fl_io carries the written byte from the setup cycle through the hold phase and is high-impedance at all other times.
- R5: A flash read holds fl_re_n low for the read wait count. The byte on fl_io is captured on the edge where fl_re_n rises, and it is returned with bus_rvalid high for exactly the first hold cycle.
- R6: The timing register at bus address 0x88 holds the write wait count (bits 3:0) and read wait count (bits 7:4); the byte at 0x89 holds the hold count (bits 3:0) and recovery count (bits 7:4). The reset value is 0x1122. A count of zero acts as one. A flash access keeps bus_ready low for 1 + wait + hold + recovery cycles.
- R7: The status byte at 0x84 has bit 0 equal to the selected ready input, inverted when control bit 7 is set, and bit 3 as the completion flag. The completion flag is 0 after reset, clears when a flash access starts and sets when its recovery ends.
- R8: Control bits 4, 5 and 6 invert the chip-select, spare-select and write-protect pins. When the bit is set, the line is active-low and idles high.
- R9: The control register reads and writes bytewise at 0x80 to 0x83 and resets to zero. A register read returns its byte with bus_rvalid high in the cycle after acceptance, and register accesses never drop bus_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Access request, accepted on an edge where bus_ready is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Bit 7 selects register space; bits 6:2 are flash line selects |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte |
| bus_rvalid | output | 1 | One-cycle pulse marking bus_rdata valid |
| bus_ready | output | 1 | High when a new access can be accepted |
| fl_cs | output | 2 | Flash chip-select lines |
| fl_ale | output | 1 | Address latch enable |
| fl_cle | output | 1 | Command latch enable |
| fl_se | output | 1 | Spare-area select |
| fl_wp | output | 1 | Write protect |
| fl_we_n | output | 1 | Write strobe, active-low |
| fl_re_n | output | 1 | Read strobe, active-low |
| fl_io | inout | 8 | Flash data bus |
| fl_rdy | input | 2 | Ready/busy inputs of the two flash sockets |

## Verification
The assertions assume that the host raises bus_req only in cycles where it sees bus_ready high. They also assume that nothing but the flash drives fl_io, and only while fl_re_n is low. The stimulus keeps to these rules. Every access task first waits for bus_ready and then drops the request after one accepted cycle. The bench flash model drives the data bus only while the read strobe is low. The random control values stay inside the defined control bits.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

    localparam int NUM_CS = 2;

    // control register bit positions
    localparam int CB_MODE    = 0;
    localparam int CB_MUX     = 1;
    localparam int CB_POL_CS  = 4;
    localparam int CB_POL_SE  = 5;
    localparam int CB_POL_WP  = 6;
    localparam int CB_POL_RDY = 7;
    localparam int CB_IN_ALT  = 8;
    localparam int CB_OUT_ALT = 10;
    localparam int CB_CE      = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RECOV
    } seq_state_e;

    typedef struct packed {
        logic ale;
        logic cle;
        logic cs;
        logic se;
        logic wp;
    } fl_lines_t;

endpackage

// File: rtl/nand_bridge_regs.sv
module nand_bridge_regs
    import nand_bridge_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int TIM_RST = 16'h1122
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc,
    input  logic                 acc_we,
    input  logic [3:0]           acc_addr,
    input  logic [7:0]           acc_wdata,
    input  logic                 rdy_line,
    input  logic                 done,
    output logic [31:0]          ctrl,
    output logic [4*CNT_W-1:0]   tim,
    output logic [7:0]           rdata,
    output logic                 rvalid
);
    localparam int TIM_W = 4 * CNT_W;
    localparam int PAD_W = 32 - TIM_W;

    typedef struct packed {
        logic [31:0]      ctrl;
        logic [TIM_W-1:0] tim;
        logic [7:0]       rdata;
        logic             rvalid;
    } regs_t;

    regs_t q, d;
    logic [31:0] tim_ext;
    logic [1:0]  lane;

    always_comb begin
        d       = q;
        d.rvalid = 1'b0;
        lane    = acc_addr[1:0];
        tim_ext = {{PAD_W{1'b0}}, q.tim};
        if (acc) begin
            if (acc_we) begin
                case (acc_addr[3:2])
                    2'd0: d.ctrl[lane*8 +: 8] = acc_wdata;
                    2'd2: begin
                        tim_ext[lane*8 +: 8] = acc_wdata;
                        d.tim = tim_ext[TIM_W-1:0];
                    end
                    default: ;
                endcase
            end else begin
                d.rvalid = 1'b1;
                case (acc_addr[3:2])
                    2'd0:    d.rdata = q.ctrl[lane*8 +: 8];
                    2'd1:    d.rdata = (lane == 2'd0) ?
                                       {4'b0, done, 2'b0, rdy_line} : 8'h00;
                    2'd2:    d.rdata = tim_ext[lane*8 +: 8];
                    default: d.rdata = 8'h00;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctrl   <= '0;
            q.tim    <= TIM_W'(TIM_RST);
            q.rdata  <= '0;
            q.rvalid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ctrl   = q.ctrl;
    assign tim    = q.tim;
    assign rdata  = q.rdata;
    assign rvalid = q.rvalid;
endmodule

// File: rtl/nand_bridge_seq.sv
module nand_bridge_seq
    import nand_bridge_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_we,
    input  fl_lines_t          start_lines,
    input  logic [7:0]         start_wdata,
    input  logic [4*CNT_W-1:0] tim,
    input  logic [7:0]         io_in,
    output logic               busy,
    output fl_lines_t          lines,
    output logic               we_n,
    output logic               re_n,
    output logic               io_oe,
    output logic [7:0]         io_out,
    output logic [7:0]         rdata,
    output logic               rvalid,
    output logic               done
);
    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             we;
        fl_lines_t        lines;
        logic [7:0]       wdata;
        logic [7:0]       rdata;
        logic             rvalid;
        logic             done;
    } seq_t;

    seq_t q, d;
    logic [CNT_W-1:0] wr_w, rd_w, hold_w, rec_w;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    always_comb begin
        wr_w   = at_least_one(tim[0*CNT_W +: CNT_W]);
        rd_w   = at_least_one(tim[1*CNT_W +: CNT_W]);
        hold_w = at_least_one(tim[2*CNT_W +: CNT_W]);
        rec_w  = at_least_one(tim[3*CNT_W +: CNT_W]);
        d        = q;
        d.rvalid = 1'b0;
        case (q.st)
            ST_IDLE: if (start) begin
                d.st    = ST_SETUP;
                d.we    = start_we;
                d.lines = start_lines;
                d.wdata = start_wdata;
                d.done  = 1'b0;
            end
            ST_SETUP: begin
                d.st  = ST_STROBE;
                d.cnt = q.we ? wr_w : rd_w;
            end
            ST_STROBE: begin
                if (q.cnt == CNT_W'(1)) begin
                    d.st  = ST_HOLD;
                    d.cnt = hold_w;
                    if (!q.we) begin
                        d.rdata  = io_in;
                        d.rvalid = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (q.cnt == CNT_W'(1)) begin
                    d.st  = ST_RECOV;
                    d.cnt = rec_w;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_RECOV: begin
                if (q.cnt == CNT_W'(1)) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    logic in_window;
    assign in_window = (q.st == ST_SETUP) || (q.st == ST_STROBE) || (q.st == ST_HOLD);
    assign busy   = (q.st != ST_IDLE);
    assign lines  = in_window ? q.lines : '0;
    assign we_n   = !((q.st == ST_STROBE) && q.we);
    assign re_n   = !((q.st == ST_STROBE) && !q.we);
    assign io_oe  = in_window && q.we;
    assign io_out = q.wdata;
    assign rdata  = q.rdata;
    assign rvalid = q.rvalid;
    assign done   = q.done;
endmodule

// File: rtl/nand_bridge_pins.sv
module nand_bridge_pins
    import nand_bridge_pkg::*;
(
    input  fl_lines_t         lines,
    input  logic              mode_en,
    input  logic              chip_en,
    input  logic              mux_en,
    input  logic              out_alt,
    input  logic              in_alt,
    input  logic              pol_cs,
    input  logic              pol_se,
    input  logic              pol_wp,
    input  logic              pol_rdy,
    input  logic [NUM_CS-1:0] rdy_in,
    output logic [NUM_CS-1:0] cs_pin,
    output logic              ale_pin,
    output logic              cle_pin,
    output logic              se_pin,
    output logic              wp_pin,
    output logic              rdy_line
);
    logic cs_on;
    logic out_sel;
    logic in_sel;

    assign cs_on   = lines.cs && mode_en && chip_en;
    assign out_sel = mux_en && out_alt;
    assign in_sel  = mux_en && in_alt;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_pin[g] = (cs_on && (32'(out_sel) == g)) ^ pol_cs;
    end

    assign ale_pin  = lines.ale;
    assign cle_pin  = lines.cle;
    assign se_pin   = lines.se ^ pol_se;
    assign wp_pin   = lines.wp ^ pol_wp;
    assign rdy_line = rdy_in[in_sel] ^ pol_rdy;
endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
    import nand_bridge_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int TIM_RST = 16'h1122
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        bus_rvalid,
    output logic        bus_ready,
    output logic [1:0]  fl_cs,
    output logic        fl_ale,
    output logic        fl_cle,
    output logic        fl_se,
    output logic        fl_wp,
    output logic        fl_we_n,
    output logic        fl_re_n,
    inout  wire  [7:0]  fl_io,
    input  logic [1:0]  fl_rdy
);
    logic               accept, reg_acc, fl_start;
    logic [31:0]        ctrl_q;
    logic [4*CNT_W-1:0] tim_q;
    logic [7:0]         reg_rdata, fl_rdata, io_out;
    logic               reg_rvalid, fl_rvalid, io_oe;
    logic               busy, done, rdy_line;
    fl_lines_t          start_lines, lines;

    assign bus_ready = !busy;
    assign accept    = bus_req && bus_ready;
    assign reg_acc   = accept && bus_addr[7];
    assign fl_start  = accept && !bus_addr[7];
    assign start_lines = '{ale: bus_addr[2], cle: bus_addr[3], cs: bus_addr[4],
                           se: bus_addr[5], wp: bus_addr[6]};

    nand_bridge_regs #(.CNT_W(CNT_W), .TIM_RST(TIM_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc(reg_acc), .acc_we(bus_we),
        .acc_addr(bus_addr[3:0]), .acc_wdata(bus_wdata), .rdy_line(rdy_line),
        .done(done), .ctrl(ctrl_q), .tim(tim_q), .rdata(reg_rdata),
        .rvalid(reg_rvalid)
    );

    nand_bridge_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(fl_start), .start_we(bus_we),
        .start_lines(start_lines), .start_wdata(bus_wdata), .tim(tim_q),
        .io_in(fl_io), .busy(busy), .lines(lines), .we_n(fl_we_n),
        .re_n(fl_re_n), .io_oe(io_oe), .io_out(io_out), .rdata(fl_rdata),
        .rvalid(fl_rvalid), .done(done)
    );

    nand_bridge_pins u_pins (
        .lines(lines), .mode_en(ctrl_q[CB_MODE]), .chip_en(ctrl_q[CB_CE]),
        .mux_en(ctrl_q[CB_MUX]), .out_alt(ctrl_q[CB_OUT_ALT]),
        .in_alt(ctrl_q[CB_IN_ALT]), .pol_cs(ctrl_q[CB_POL_CS]),
        .pol_se(ctrl_q[CB_POL_SE]), .pol_wp(ctrl_q[CB_POL_WP]),
        .pol_rdy(ctrl_q[CB_POL_RDY]), .rdy_in(fl_rdy), .cs_pin(fl_cs),
        .ale_pin(fl_ale), .cle_pin(fl_cle), .se_pin(fl_se), .wp_pin(fl_wp),
        .rdy_line(rdy_line)
    );

    assign fl_io      = io_oe ? io_out : 8'hzz;
    assign bus_rvalid = reg_rvalid || fl_rvalid;
    assign bus_rdata  = fl_rvalid ? fl_rdata : reg_rdata;
endmodule

// File: rtl/nand_bridge_chk.sv
module nand_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctrl,
    input logic [1:0]  fl_cs,
    input logic        fl_we_n,
    input logic        fl_re_n,
    input logic        bus_ready,
    input logic        bus_rvalid,
    input logic        io_oe
);
    // R2
    cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl[0] && ctrl[20]) |-> (fl_cs == {2{ctrl[4]}}));

    // R6
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_re_n) |-> !bus_ready);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_re_n));

    // R5
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_re_n) |-> bus_rvalid);

    // R4
    io_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> fl_re_n);
endmodule

bind nand_bridge nand_bridge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .fl_cs(fl_cs),
    .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .bus_ready(bus_ready),
    .bus_rvalid(bus_rvalid), .io_oe(io_oe)
);

// File: tb/nand_bridge_tb.sv
module nand_bridge_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bus_rvalid, bus_ready;
    logic [1:0] fl_cs;
    logic       fl_ale, fl_cle, fl_se, fl_wp, fl_we_n, fl_re_n;
    wire  [7:0] fl_io;
    logic [1:0] fl_rdy;
    logic       rdy_alt = 1'b1;
    logic [7:0] flash_byte = 8'h00;
    int         busy_cnt = 0;

    int checks = 0, failures = 0;
    logic [31:0] sh_ctrl = 32'h0;
    int w_rd = 2, w_wr = 2, w_hold = 1, w_rec = 1;

    always #2.5 clk = ~clk;

    // flash model: drives data while read strobe low, busy after a command
    assign fl_io = (fl_re_n == 1'b0) ? flash_byte : 8'hzz;
    always @(negedge clk) begin
        if (fl_we_n == 1'b0 && fl_cle) busy_cnt = 20;
        else if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    end
    assign fl_rdy = {rdy_alt, (busy_cnt == 0)};

    nand_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bus_ready(bus_ready), .fl_cs(fl_cs),
        .fl_ale(fl_ale), .fl_cle(fl_cle), .fl_se(fl_se), .fl_wp(fl_wp),
        .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_io(fl_io), .fl_rdy(fl_rdy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int nz(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [7:0] v, input string tag);
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        v = bus_rdata;
        chk(bus_rvalid && bus_ready, tag, {bus_rvalid, bus_ready}, 3);
    endtask

    task automatic set_ctrl(input logic [31:0] c);
        reg_wr(8'h80, c[7:0]);
        reg_wr(8'h81, c[15:8]);
        reg_wr(8'h82, c[23:16]);
        sh_ctrl = c;
    endtask

    task automatic set_tim(input int wr, input int rd, input int hd, input int rc);
        reg_wr(8'h88, 8'((rd << 4) | wr));
        reg_wr(8'h89, 8'((rc << 4) | hd));
        w_wr = nz(wr); w_rd = nz(rd); w_hold = nz(hd); w_rec = nz(rc);
    endtask

    task automatic flash_acc(input bit we, input logic [6:0] off, input logic [7:0] wd,
                             input logic [7:0] pat);
        int cyc, wt, e_line, e_cs, e_we, e_re, e_io, e_rv;
        bit win, strb, cs_on, alt;
        logic [1:0] exp_cs;
        logic [7:0] exp_io;
        wt = we ? w_wr : w_rd;
        flash_byte = pat;
        e_line = 0; e_cs = 0; e_we = 0; e_re = 0; e_io = 0; e_rv = 0;
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = {1'b0, off}; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        cyc = 1;
        while (!bus_ready && cyc < 100) begin
            win  = (cyc <= 1 + wt + w_hold);
            strb = (cyc >= 2) && (cyc <= 1 + wt);
            cs_on = win && off[4] && sh_ctrl[0] && sh_ctrl[20];
            alt   = sh_ctrl[1] && sh_ctrl[10];
            exp_cs = {cs_on && alt, cs_on && !alt} ^ {2{sh_ctrl[4]}};
            if (fl_ale !== (win && off[2]) || fl_cle !== (win && off[3]) ||
                fl_se !== ((win && off[5]) ^ sh_ctrl[5]) ||
                fl_wp !== ((win && off[6]) ^ sh_ctrl[6])) e_line++;
            if (fl_cs !== exp_cs) e_cs++;
            if (fl_we_n !== !(we && strb)) e_we++;
            if (fl_re_n !== !(!we && strb)) e_re++;
            exp_io = (we && win) ? wd : ((!we && strb) ? pat : 8'hzz);
            if (fl_io !== exp_io) e_io++;
            if (bus_rvalid !== (!we && cyc == wt + 2)) e_rv++;
            if (!we && cyc == wt + 2 && bus_rdata !== pat) e_rv++;
            @(negedge clk);
            cyc++;
        end
        chk(e_line == 0, "R1 R8 line levels", e_line, 0);
        chk(e_cs == 0, "R2 R3 R8 chip select", e_cs, 0);
        if (we) chk(e_we == 0 && e_io == 0, "R4 write strobe/data", e_we + e_io, 0);
        else    chk(e_re == 0 && e_rv == 0 && e_io == 0, "R5 read strobe/data",
                    e_re + e_rv + e_io, 0);
        chk(cyc - 1 == 1 + wt + w_hold + w_rec, "R6 busy length", cyc - 1,
            1 + wt + w_hold + w_rec);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(bus_ready && !bus_rvalid && fl_we_n && fl_re_n, "R6 reset idle",
            {bus_ready, bus_rvalid, fl_we_n, fl_re_n}, 4'b1011);
        chk(fl_cs == 2'b00 && fl_io === 8'hzz, "R2 R4 reset pins", fl_cs, 0);
        reg_rd(8'h84, v, "R9 status rd"); chk(v == 8'h01, "R7 reset status", v, 8'h01);
        reg_rd(8'h88, v, "R9 tim rd");    chk(v == 8'h22, "R6 timing reset lo", v, 8'h22);
        reg_rd(8'h89, v, "R9 tim rd");    chk(v == 8'h11, "R6 timing reset hi", v, 8'h11);
        reg_rd(8'h82, v, "R9 ctrl rd");   chk(v == 8'h00, "R9 ctrl reset", v, 0);

        // enable flash mode and chip enable, read back
        set_ctrl(32'h0010_0001);
        reg_rd(8'h80, v, "R9 ctrl rd"); chk(v == 8'h01, "R9 ctrl byte0", v, 8'h01);
        reg_rd(8'h82, v, "R9 ctrl rd"); chk(v == 8'h10, "R9 ctrl byte2", v, 8'h10);

        // command write, then status with flash busy then ready
        flash_acc(1'b1, 7'h18, 8'h70, 8'h00);
        reg_rd(8'h84, v, "R9 status rd"); chk(v == 8'h08, "R7 done, flash busy", v, 8'h08);
        repeat (30) @(negedge clk);
        reg_rd(8'h84, v, "R9 status rd"); chk(v == 8'h09, "R7 done, flash ready", v, 8'h09);

        // address, data write, data read
        flash_acc(1'b1, 7'h14, 8'h3c, 8'h00);
        flash_acc(1'b1, 7'h10, 8'ha5, 8'h00);
        flash_acc(1'b0, 7'h10, 8'h00, 8'h5a);

        // mode off: chip select must stay inactive
        set_ctrl(32'h0000_0001);
        flash_acc(1'b1, 7'h10, 8'h11, 8'h00);
        set_ctrl(32'h0010_0000);
        flash_acc(1'b0, 7'h10, 8'h00, 8'hc3);

        // second chip select and alternate ready input
        set_ctrl(32'h0010_0503);
        rdy_alt = 1'b0;
        flash_acc(1'b1, 7'h10, 8'h77, 8'h00);
        reg_rd(8'h84, v, "R9 status rd"); chk(v[0] == 1'b0, "R3 alt ready in", v[0], 0);
        rdy_alt = 1'b1;
        set_ctrl(32'h0010_0103);
        flash_acc(1'b1, 7'h10, 8'h78, 8'h00);

        // polarities, including ready polarity
        set_ctrl(32'h0010_00f3);
        @(negedge clk);
        chk(fl_cs == 2'b11 && fl_se && fl_wp, "R8 idle inverted", {fl_cs, fl_se, fl_wp}, 4'hf);
        flash_acc(1'b1, 7'h70, 8'h99, 8'h00);
        reg_rd(8'h84, v, "R9 status rd"); chk(v[0] == 1'b0, "R7 R8 ready polarity", v[0], 0);

        // zero counts behave as one
        set_ctrl(32'h0010_0001);
        set_tim(0, 0, 0, 0);
        flash_acc(1'b1, 7'h10, 8'h01, 8'h00);
        flash_acc(1'b0, 7'h10, 8'h00, 8'h81);
        set_tim(7, 5, 3, 6);
        flash_acc(1'b0, 7'h14, 8'h00, 8'h42);

        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [31:0] c;
            c = {11'b0, 1'($urandom_range(0, 3) != 0), 9'b0, 1'($urandom),
                 1'b0, 1'($urandom), 1'b0, 3'($urandom), 2'b0,
                 1'($urandom), 1'($urandom_range(0, 3) != 0)};
            set_ctrl(c);
            set_tim($urandom_range(0, 7), $urandom_range(0, 7),
                    $urandom_range(0, 7), $urandom_range(0, 7));
            flash_acc(1'($urandom), 7'($urandom_range(0, 31) << 2),
                      8'($urandom), 8'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule